// File: doc/BRIEF.md
# Paged SPI Slave Memory Front End

This block connects a 64-byte space, split into eight pages of eight bytes, to an SPI bus as a slave. It runs on a local clock. It synchronises the chip-select, serial clock and serial data inputs, then finds the edges of the serial clock. A frame opens when chip-select falls. The first byte is a header that carries a marker bit, a six-bit device address and a direction bit. The second byte gives the start location. After those two bytes, the block either streams bytes out of the memory port or collects bytes for a write. Both bytes are sent MSB first.

Reads move through the whole space and wrap from 3Fh to 00h. Writes stay inside the page named by the start location. The write bytes go into an eight-entry page buffer first. When chip-select rises, the buffered bytes are copied to the memory port, one byte per clock. A bad header or an out-of-range location turns the rest of the frame into a no-op.

Top module: `spi_page_mem`

## Requirements
- R1: After reset, `so_oe` and `so` are 0 and `mem_we` stays 0 until a write frame has been committed.
- R2: The first byte after chip-select falls is taken MSB first. Bit 7 must be 1 and bits 6..1 must equal `dev_addr`; bit 0 selects read (1) or write (0). If either field is wrong, the frame is aborted: no SO drive and no memory write until the next frame.
- R3: The second byte is the start location. A value above 3Fh aborts the frame in the same way as R2.
- R4: A read drives the first data bit on the first SCK falling edge after the rising edge that samples the last location bit. Bytes go out MSB first, and the pointer steps by one per byte, wrapping from 3Fh to 00h.
- R5: `so_oe` is 1 only while read data is being shifted. It is 0 during the header bytes and after chip-select rises.
- R6: Write data lands at consecutive locations inside the start page, wrapping from offset 7 to offset 0 while the page stays fixed. A ninth or later byte overwrites the earlier byte at the same offset.
- R7: Writes reach memory only after chip-select rises, and only if at least one complete data byte was received. A trailing partial byte is dropped.
- R8: While `stall` is 1, rising SCK edges are not sampled.
- R9: A chip-select rise at any bit position clears the bit and byte progress, so the next frame starts with a fresh header.
- R10: A commit writes at most one byte per clock, and all bytes of one commit go to the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (1 = driven) |
| dev_addr | input | 6 | Device address pins |
| stall | input | 1 | Not-ready flag; blocks SI sampling when 1 |
| mem_addr | output | 6 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, combinational on `mem_addr` |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
The assertions assume that each SCK level and each chip-select level lasts for several local clocks, so the synchroniser sees every edge. They also assume that a new frame never opens while a commit is still running. The bench holds each SCK half period for six clocks. After every chip-select rise it waits more than the eight commit cycles before it opens the next frame. It changes `stall` only while SCK is low.

// File: rtl/spi_page_mem.sv
module spi_page_mem #(
  parameter int AW = 6,
  parameter int PW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic [DW-3:0] dev_addr,
  input  logic          stall,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);
  localparam int BW   = $clog2(DW);
  localparam int PAGE = 1 << PW;
  localparam int TOP  = (1 << AW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_LOC, S_RD, S_WR, S_ABT} st_t;
  st_t st;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic [BW-1:0] bcnt, tcnt;
  logic [DW-2:0] rx;
  logic [DW-1:0] tx;
  logic rw, tx_on, cmt;
  logic [AW-1:0] ptr;
  logic [PW-1:0] cidx;
  logic [PAGE-1:0] vld;
  logic [DW-1:0] wbuf [PAGE];

  wire cs_hi    = cs_q[1];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire rx_st    = (st == S_HDR) || (st == S_LOC) || (st == S_WR);
  wire take     = sck_rise & ~cs_hi & ~stall & rx_st;
  wire [DW-1:0] rbyte = {rx, si_q[1]};
  wire done     = take && (bcnt == BW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      bcnt  <= '0;
      tcnt  <= '0;
      rx    <= '0;
      tx    <= '0;
      rw    <= 1'b0;
      tx_on <= 1'b0;
      ptr   <= '0;
      vld   <= '0;
      cmt   <= 1'b0;
      cidx  <= '0;
    end else begin
      if (take) begin
        rx   <= rbyte[DW-2:0];
        bcnt <= bcnt + 1'b1;
      end
      if (cs_fall) begin
        st    <= S_HDR;
        bcnt  <= '0;
        tcnt  <= '0;
        tx_on <= 1'b0;
      end else if (cs_hi) begin
        st    <= S_IDLE;
        bcnt  <= '0;
        tcnt  <= '0;
        tx_on <= 1'b0;
        if (cs_rise && st == S_WR && |vld) begin
          cmt  <= 1'b1;
          cidx <= '0;
        end
      end else if (done) begin
        case (st)
          S_HDR:
            if (rbyte[DW-1] && rbyte[DW-2:1] == dev_addr) begin
              rw <= rbyte[0];
              st <= S_LOC;
            end else st <= S_ABT;
          S_LOC:
            if (rbyte > DW'(TOP)) st <= S_ABT;
            else begin
              ptr <= rbyte[AW-1:0];
              st  <= rw ? S_RD : S_WR;
            end
          S_WR: begin
            vld[ptr[PW-1:0]] <= 1'b1;
            ptr[PW-1:0]      <= ptr[PW-1:0] + 1'b1;
          end
          default: ;
        endcase
      end else if (st == S_RD && sck_fall) begin
        tx_on <= 1'b1;
        tcnt  <= tcnt + 1'b1;
        if (tcnt == '0) begin
          tx  <= mem_rdata;
          ptr <= ptr + 1'b1;
        end else tx <= {tx[DW-2:0], 1'b0};
      end
      if (cmt) begin
        cidx <= cidx + 1'b1;
        if (cidx == PW'(PAGE - 1)) begin
          cmt <= 1'b0;
          vld <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (!cs_hi && done && st == S_WR) wbuf[ptr[PW-1:0]] <= rbyte;

  assign so_oe     = tx_on && st == S_RD;
  assign so        = so_oe & tx[DW-1];
  assign mem_addr  = cmt ? {ptr[AW-1:PW], cidx} : ptr;
  assign mem_we    = cmt & vld[cidx];
  assign mem_wdata = wbuf[cidx];

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABT && !cs_hi) |=> st == S_ABT); // R2
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && sck_fall && !cs_hi && tcnt == '0) |=> ptr == AW'($past(ptr) + 1'b1)); // R4
  AST_HIZ_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_hi) |=> !so_oe); // R5
  AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cs_hi); // R7
  AST_STALL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && sck_rise && !cs_hi) |=> $stable(bcnt)); // R8
  AST_PAGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])); // R10
endmodule

// File: tb/spi_page_mem_tb.sv
module spi_page_mem_tb;
  localparam int H = 6;
  localparam logic [5:0] DEV = 6'h2B;
  // kind[15:12]: 0 write, 1 read, 2 write bad dev, 3 write bad loc, 4 read bad dev; loc[11:4]; count[3:0]
  localparam logic [15:0] VEC [10] = '{
    {4'd0, 8'h05, 4'd6}, {4'd1, 8'h00, 4'd8}, {4'd0, 8'h3C, 4'd3},
    {4'd1, 8'h3E, 4'd4}, {4'd0, 8'h12, 4'd10}, {4'd1, 8'h10, 4'd8},
    {4'd2, 8'h20, 4'd2}, {4'd3, 8'h47, 4'd2}, {4'd4, 8'h00, 4'd3},
    {4'd1, 8'h38, 4'd8}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, stall = 0;
  logic so, so_oe, mem_we;
  logic [5:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int total = 0, bad = 0, oe_cnt = 0, we_cnt = 0;
  logic oe_last;

  always #2.5 clk = ~clk;

  spi_page_mem u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .dev_addr(DEV), .stall(stall), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] initv(int i);
    return 8'(i * 37 + 11);
  endfunction

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 64; i++) mem[i] <= initv(i);
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    if (so_oe) oe_cnt <= oe_cnt + 1;
    if (mem_we) we_cnt <= we_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int first = -1;
    for (int i = 0; i < 64; i++) if (first < 0 && mem[i] !== exp_mem[i]) first = i;
    if (first < 0) check(1, req, "memory", 0, 0);
    else check(0, req, $sformatf("memory @%0h", first), mem[first], exp_mem[first]);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      repeat (H) @(negedge clk);
      r[i] = so;
      oe_last = so_oe;
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic frame(input logic [7:0] id, input logic [7:0] loc, input bit rd, input int n,
                       input logic [7:0] seed, input bit ok, input int tail, input string req);
    logic [7:0] r, b;
    int oe0, we0;
    oe0 = oe_cnt;
    we0 = we_cnt;
    cs_n = 0;
    repeat (H) @(negedge clk);
    xfer(id, r);
    xfer(loc, r);
    if (rd && ok) check(oe_last == 0, "R5", "so_oe during location byte", oe_last, 0);
    for (int j = 0; j < n; j++) begin
      b = 8'(seed + j * 29);
      xfer(rd ? 8'h00 : b, r);
      if (rd && ok) begin
        check(r == exp_mem[(loc + j) & 63], "R4", $sformatf("read byte %0d", j), r, exp_mem[(loc + j) & 63]);
        check(oe_last == 1, "R5", "so_oe while shifting", oe_last, 1);
      end
      if (!rd && ok) exp_mem[{loc[5:3], 3'(loc[2:0] + j)}] = b;
    end
    for (int t = 0; t < tail; t++) begin
      si = 1;
      repeat (H) @(negedge clk);
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (24) @(negedge clk);
    check(so_oe == 0, "R5", "so_oe after cs rise", so_oe, 0);
    if (!ok) begin
      check(oe_cnt == oe0, req, "so_oe cycles in aborted frame", oe_cnt - oe0, 0);
      check(we_cnt == we0, req, "writes in aborted frame", we_cnt - we0, 0);
    end
    if (!rd) chk_mem(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "timeout", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int kind, n;
    logic [7:0] loc;
    for (int i = 0; i < 64; i++) exp_mem[i] = initv(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(so_oe == 0 && so == 0, "R1", "so/so_oe after reset", {so, so_oe}, 0);
    check(mem_we == 0, "R1", "mem_we after reset", mem_we, 0);

    for (int k = 0; k < 10; k++) begin
      kind = int'(VEC[k][15:12]);
      loc  = VEC[k][11:4];
      n    = int'(VEC[k][3:0]);
      case (kind)
        0: frame({1'b1, DEV, 1'b0}, loc, 0, n, 8'(k * 16 + 3), 1, 0, "R6");
        1: frame({1'b1, DEV, 1'b1}, loc, 1, n, 8'h00, 1, 0, "R4");
        2: frame({1'b1, DEV ^ 6'h01, 1'b0}, loc, 0, n, 8'h77, 0, 0, "R2");
        3: frame({1'b1, DEV, 1'b0}, loc, 0, n, 8'h66, 0, 0, "R3");
        default: frame({1'b1, DEV ^ 6'h20, 1'b1}, loc, 1, n, 8'h00, 0, 0, "R2");
      endcase
    end

    // R2: marker bit cleared
    frame({1'b0, DEV, 1'b0}, 8'h00, 0, 2, 8'h44, 0, 0, "R2");
    // R7: trailing partial byte dropped
    frame({1'b1, DEV, 1'b0}, 8'h21, 0, 2, 8'h90, 1, 3, "R7");
    // R7: no data byte, nothing committed
    frame({1'b1, DEV, 1'b0}, 8'h28, 0, 0, 8'h00, 0, 0, "R7");
    // R10: full page commit after 8 bytes at an offset
    frame({1'b1, DEV, 1'b0}, 8'h2B, 0, 8, 8'hC1, 1, 0, "R10");

    // R8: byte sent while stalled is not received
    cs_n = 0;
    repeat (H) @(negedge clk);
    xfer({1'b1, DEV, 1'b0}, r);
    xfer(8'h30, r);
    stall = 1;
    xfer(8'hAA, r);
    stall = 0;
    xfer(8'h55, r);
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (24) @(negedge clk);
    exp_mem[8'h30] = 8'h55;
    chk_mem("R8");

    // R9: chip-select rise mid-header, then a clean frame
    cs_n = 0;
    repeat (H) @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      si = 1;
      repeat (H) @(negedge clk);
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
    cs_n = 1;
    repeat (24) @(negedge clk);
    frame({1'b1, DEV, 1'b0}, 8'h08, 0, 1, 8'h3D, 1, 0, "R9");
    frame({1'b1, DEV, 1'b1}, 8'h07, 1, 3, 8'h00, 1, 0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule